// File: doc/BRIEF.md
# Interrupt Enable Flag Controller

This block keeps the enable flag for external maskable interrupts in a small processor core. It watches the instruction retire stream. When a set-interrupt or clear-interrupt instruction retires, it checks the execution mode and the two privilege levels. It then either updates the flag or reports a general-protection fault with error code zero. In the fault case the flag keeps its value.

A newly set flag does not let interrupts in at once. One further instruction must retire first, so a routine can turn interrupts back on just before its return instruction. The block gates external maskable requests with the flag and this one-instruction shadow. Non-maskable interrupts and exceptions pass straight through.

The block has no decoder, no fault handler and no register file. It sees only retire pulses, the retired opcode byte and the mode and privilege inputs. All of these are sampled in the cycle the retire pulse is high.

Top module: `iflag_ctrl`

## Requirements
- R1: After synchronous reset, `iflag_o`, `ext_irq_take` and `gp_fault` are all 0, and no shadow is pending.
- R2: In real mode (`prot_en`=0, `v86_en` ignored), a retired set instruction (opcode 0xFB) sets the flag without a fault, for any `cur_pl` and `io_pl`.
- R3: In protected mode (`prot_en`=1, `v86_en`=0), a set instruction sets the flag when `cur_pl` <= `io_pl`. Otherwise `gp_fault` is raised and the flag keeps its value.
- R4: In virtual-8086 mode (`prot_en`=1, `v86_en`=1), a set instruction sets the flag only when `io_pl` = 3. Otherwise `gp_fault` is raised and the flag keeps its value.
- R5: A retired clear instruction (opcode 0xFA) passes the same mode and privilege check. On success it clears the flag. On failure it raises `gp_fault` and the flag keeps its value.
- R6: A set that changes the flag from 0 to 1 arms a shadow. While the shadow is armed, `ext_irq_take` stays 0. The next retire pulse of any instruction clears the shadow. After that, `ext_irq_take` = `ext_irq_req` AND flag.
- R7: A clear that retires directly after an enabling set leaves `ext_irq_take` at 0 throughout, with no acceptance window.
- R8: A set that retires while the flag is already 1 arms no shadow, and `ext_irq_take` stays 1 without a gap.
- R9: `nmi_take` equals `nmi_req` and `exc_take` equals `exc_req` in every cycle, whatever the flag and shadow.
- R10: `gp_fault` is high only in a cycle with `retire_vld`=1 and a set or clear opcode. It lasts exactly that cycle, and `gp_err_code` reads 0.
- R11: A retired opcode other than 0xFB or 0xFA changes neither the flag nor `gp_fault`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| retire_vld | input | 1 | One-cycle pulse per retired instruction |
| retire_opc | input | 8 | Opcode byte of the retiring instruction |
| prot_en | input | 1 | Protection enable (0 = real mode) |
| v86_en | input | 1 | Virtual-8086 mode bit |
| cur_pl | input | 2 | Current privilege level |
| io_pl | input | 2 | I/O privilege level |
| ext_irq_req | input | 1 | External maskable interrupt request |
| nmi_req | input | 1 | Non-maskable interrupt request |
| exc_req | input | 1 | Exception request |
| iflag_o | output | 1 | Current interrupt enable flag |
| ext_irq_take | output | 1 | External request accepted |
| nmi_take | output | 1 | Non-maskable request accepted |
| exc_take | output | 1 | Exception accepted |
| gp_fault | output | 1 | General-protection fault, combinational with the retire |
| gp_err_code | output | 16 | Fault error code, always zero |

## Verification
The assertions check these properties on every cycle:
- a fault appears only together with a set or clear retire, and leaves the flag unchanged;
- the flag rises only with the shadow armed;
- an armed shadow blocks acceptance, and the next retire clears it;
- any acceptance implies both a request and a set flag;
- real mode never refuses a set;
- virtual-8086 mode with a level below 3 always faults.

Only the bench scenarios can show the sequences:
- exactly one instruction of delay before acceptance opens;
- a set followed by a clear gives no window at all;
- a second set gives no gap;
- non-maskable and exception requests pass through while the shadow is armed.

// File: rtl/iflag_pkg.sv
package iflag_pkg;

  // Kind of instruction seen at retire
  typedef enum logic [1:0] {
    IOP_NONE = 2'd0,
    IOP_SET  = 2'd1,
    IOP_CLR  = 2'd2
  } iop_e;

  // Execution mode resolved from the two mode bits
  typedef enum logic [1:0] {
    MODE_REAL = 2'd0,
    MODE_PROT = 2'd1,
    MODE_V86  = 2'd2
  } mode_e;

  // The protection-enable bit dominates: with it low the v86 bit is ignored.
  function automatic mode_e mode_of(input logic pe, input logic vm);
    mode_e m;
    if (!pe)     m = MODE_REAL;
    else if (vm) m = MODE_V86;
    else         m = MODE_PROT;
    return m;
  endfunction

  // Decision table for flag writes; levels are passed widened to int.
  function automatic logic level_ok(input mode_e m, input int cpl,
                                    input int iopl, input int pl_max);
    logic ok;
    case (m)
      MODE_REAL: ok = 1'b1;
      MODE_PROT: ok = (cpl <= iopl);
      MODE_V86:  ok = (iopl == pl_max);
      default:   ok = 1'b0;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/iflag_decode.sv
module iflag_decode
  import iflag_pkg::*;
#(
  parameter int OPC_W = 8,
  parameter logic [OPC_W-1:0] SET_OPC = 8'hFB,
  parameter logic [OPC_W-1:0] CLR_OPC = 8'hFA
) (
  input  logic             retire_vld,
  input  logic [OPC_W-1:0] retire_opc,
  output iop_e             op_kind
);

  always_comb begin
    op_kind = IOP_NONE;
    if (retire_vld) begin
      if (retire_opc == SET_OPC)      op_kind = IOP_SET;
      else if (retire_opc == CLR_OPC) op_kind = IOP_CLR;
    end
  end

endmodule

// File: rtl/iflag_priv.sv
module iflag_priv
  import iflag_pkg::*;
#(
  parameter int PL_W = 2
) (
  input  iop_e            op_kind,
  input  logic            prot_en,
  input  logic            v86_en,
  input  logic [PL_W-1:0] cur_pl,
  input  logic [PL_W-1:0] io_pl,
  output logic            op_allow,
  output logic            op_fault
);

  localparam int PL_MAX = (1 << PL_W) - 1;

  mode_e mode_w;
  logic  level_pass;

  assign mode_w     = mode_of(prot_en, v86_en);
  assign level_pass = level_ok(mode_w, int'(cur_pl), int'(io_pl), PL_MAX);

  // Only set and clear instructions are subject to the check.
  assign op_allow = (op_kind != IOP_NONE) &&  level_pass;
  assign op_fault = (op_kind != IOP_NONE) && !level_pass;

endmodule

// File: rtl/iflag_state.sv
module iflag_state
  import iflag_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic retire_vld,
  input  iop_e op_kind,
  input  logic op_allow,
  output logic flag_q,
  output logic shadow_q,
  output logic arm_ev,
  output logic shadow_end_ev
);

  logic flag_d;
  logic shadow_d;

  // Arming happens only on a 0 -> 1 transition of the flag.
  assign arm_ev        = op_allow && (op_kind == IOP_SET) && !flag_q;
  assign shadow_end_ev = shadow_q && retire_vld;

  always_comb begin
    flag_d = flag_q;
    if (op_allow) begin
      if (op_kind == IOP_SET)      flag_d = 1'b1;
      else if (op_kind == IOP_CLR) flag_d = 1'b0;
    end
  end

  always_comb begin
    shadow_d = shadow_q;
    if (arm_ev)          shadow_d = 1'b1;
    else if (retire_vld) shadow_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q   <= 1'b0;
      shadow_q <= 1'b0;
    end else begin
      flag_q   <= flag_d;
      shadow_q <= shadow_d;
    end
  end

endmodule

// File: rtl/iflag_gate.sv
module iflag_gate (
  input  logic flag_q,
  input  logic shadow_q,
  input  logic ext_irq_req,
  input  logic nmi_req,
  input  logic exc_req,
  output logic ext_irq_take,
  output logic nmi_take,
  output logic exc_take
);

  // Only the maskable path depends on the flag and the shadow.
  assign ext_irq_take = ext_irq_req && flag_q && !shadow_q;
  assign nmi_take     = nmi_req;
  assign exc_take     = exc_req;

endmodule

// File: rtl/iflag_ctrl.sv
module iflag_ctrl
  import iflag_pkg::*;
#(
  parameter int OPC_W = 8,
  parameter int PL_W  = 2,
  parameter int ERR_W = 16,
  parameter logic [OPC_W-1:0] SET_OPC = 8'hFB,
  parameter logic [OPC_W-1:0] CLR_OPC = 8'hFA
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             retire_vld,
  input  logic [OPC_W-1:0] retire_opc,
  input  logic             prot_en,
  input  logic             v86_en,
  input  logic [PL_W-1:0]  cur_pl,
  input  logic [PL_W-1:0]  io_pl,
  input  logic             ext_irq_req,
  input  logic             nmi_req,
  input  logic             exc_req,
  output logic             iflag_o,
  output logic             ext_irq_take,
  output logic             nmi_take,
  output logic             exc_take,
  output logic             gp_fault,
  output logic [ERR_W-1:0] gp_err_code
);

  // Named internal events, brought out for the checker
  iop_e op_kind_w;
  logic op_allow_w;
  logic op_fault_w;
  logic flag_w;
  logic shadow_w;
  logic arm_ev_w;
  logic shadow_end_w;

  iflag_decode #(
    .OPC_W   (OPC_W),
    .SET_OPC (SET_OPC),
    .CLR_OPC (CLR_OPC)
  ) u_decode (
    .retire_vld (retire_vld),
    .retire_opc (retire_opc),
    .op_kind    (op_kind_w)
  );

  iflag_priv #(
    .PL_W (PL_W)
  ) u_priv (
    .op_kind  (op_kind_w),
    .prot_en  (prot_en),
    .v86_en   (v86_en),
    .cur_pl   (cur_pl),
    .io_pl    (io_pl),
    .op_allow (op_allow_w),
    .op_fault (op_fault_w)
  );

  iflag_state u_state (
    .clk           (clk),
    .rst           (rst),
    .retire_vld    (retire_vld),
    .op_kind       (op_kind_w),
    .op_allow      (op_allow_w),
    .flag_q        (flag_w),
    .shadow_q      (shadow_w),
    .arm_ev        (arm_ev_w),
    .shadow_end_ev (shadow_end_w)
  );

  iflag_gate u_gate (
    .flag_q       (flag_w),
    .shadow_q     (shadow_w),
    .ext_irq_req  (ext_irq_req),
    .nmi_req      (nmi_req),
    .exc_req      (exc_req),
    .ext_irq_take (ext_irq_take),
    .nmi_take     (nmi_take),
    .exc_take     (exc_take)
  );

  assign iflag_o     = flag_w;
  assign gp_fault    = op_fault_w;
  assign gp_err_code = '0;

endmodule

// File: rtl/iflag_ctrl_chk.sv
module iflag_ctrl_chk #(
  parameter int OPC_W = 8,
  parameter int PL_W  = 2,
  parameter logic [OPC_W-1:0] SET_OPC = 8'hFB,
  parameter logic [OPC_W-1:0] CLR_OPC = 8'hFA
) (
  input logic             clk,
  input logic             rst,
  input logic             retire_vld,
  input logic [OPC_W-1:0] retire_opc,
  input logic             prot_en,
  input logic             v86_en,
  input logic [PL_W-1:0]  io_pl,
  input logic             ext_irq_req,
  input logic             ext_irq_take,
  input logic             iflag_o,
  input logic             shadow_q,
  input logic             arm_ev,
  input logic             shadow_end_ev,
  input logic             gp_fault
);

  localparam logic [PL_W-1:0] PL_TOP = {PL_W{1'b1}};

  logic is_flag_op;
  assign is_flag_op = retire_vld && (retire_opc == SET_OPC || retire_opc == CLR_OPC);

  p_fault_needs_op_r10: assert property (@(posedge clk) disable iff (rst)
    gp_fault |-> is_flag_op);

  p_fault_keeps_flag_r3: assert property (@(posedge clk) disable iff (rst)
    gp_fault |=> (iflag_o == $past(iflag_o)));

  p_rise_arms_shadow_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(iflag_o) |-> shadow_q);

  p_arm_event_r6: assert property (@(posedge clk) disable iff (rst)
    arm_ev |=> (shadow_q && iflag_o));

  p_shadow_blocks_r6: assert property (@(posedge clk) disable iff (rst)
    shadow_q |-> !ext_irq_take);

  p_shadow_ends_r6: assert property (@(posedge clk) disable iff (rst)
    (shadow_end_ev && !arm_ev) |=> !shadow_q);

  p_take_needs_flag_r6: assert property (@(posedge clk) disable iff (rst)
    ext_irq_take |-> (iflag_o && ext_irq_req));

  p_real_sets_r2: assert property (@(posedge clk) disable iff (rst)
    (retire_vld && retire_opc == SET_OPC && !prot_en) |=> iflag_o);

  p_v86_faults_r4: assert property (@(posedge clk) disable iff (rst)
    (is_flag_op && prot_en && v86_en && io_pl != PL_TOP) |-> gp_fault);

  p_clear_drops_r5: assert property (@(posedge clk) disable iff (rst)
    (retire_vld && retire_opc == CLR_OPC && !gp_fault) |=> !iflag_o);

endmodule

bind iflag_ctrl iflag_ctrl_chk #(
  .OPC_W   (OPC_W),
  .PL_W    (PL_W),
  .SET_OPC (SET_OPC),
  .CLR_OPC (CLR_OPC)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .retire_vld    (retire_vld),
  .retire_opc    (retire_opc),
  .prot_en       (prot_en),
  .v86_en        (v86_en),
  .io_pl         (io_pl),
  .ext_irq_req   (ext_irq_req),
  .ext_irq_take  (ext_irq_take),
  .iflag_o       (iflag_o),
  .shadow_q      (shadow_w),
  .arm_ev        (arm_ev_w),
  .shadow_end_ev (shadow_end_w),
  .gp_fault      (gp_fault)
);

// File: tb/iflag_ctrl_tb.sv
module iflag_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] OP_STI = 8'hFB;
  localparam logic [7:0] OP_CLI = 8'hFA;
  localparam logic [7:0] OP_NOP = 8'h90;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        retire_vld = 1'b0;
  logic [7:0]  retire_opc = 8'h00;
  logic        prot_en = 1'b0;
  logic        v86_en = 1'b0;
  logic [1:0]  cur_pl = 2'd0;
  logic [1:0]  io_pl = 2'd0;
  logic        ext_irq_req = 1'b0;
  logic        nmi_req = 1'b0;
  logic        exc_req = 1'b0;
  logic        iflag_o;
  logic        ext_irq_take;
  logic        nmi_take;
  logic        exc_take;
  logic        gp_fault;
  logic [15:0] gp_err_code;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  iflag_ctrl u_dut (
    .clk (clk), .rst (rst), .retire_vld (retire_vld), .retire_opc (retire_opc),
    .prot_en (prot_en), .v86_en (v86_en), .cur_pl (cur_pl), .io_pl (io_pl),
    .ext_irq_req (ext_irq_req), .nmi_req (nmi_req), .exc_req (exc_req),
    .iflag_o (iflag_o), .ext_irq_take (ext_irq_take), .nmi_take (nmi_take),
    .exc_take (exc_take), .gp_fault (gp_fault), .gp_err_code (gp_err_code)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Bench view of the privilege table, written as a flat rule set.
  function automatic bit may_write(input bit pe, input bit vm,
                                   input int cpl, input int iopl);
    if (pe == 1'b0) return 1'b1;
    if (vm == 1'b1) return iopl == 3;
    return !(cpl > iopl);
  endfunction

  // Called at a falling edge; leaves the bench at the next falling edge.
  task automatic do_retire(input logic [7:0] opc, input bit pe, input bit vm,
                           input int cpl, input int iopl, input string req);
    bit exp_f;
    retire_vld = 1'b1; retire_opc = opc; prot_en = pe; v86_en = vm;
    cur_pl = 2'(cpl); io_pl = 2'(iopl);
    exp_f = (opc == OP_STI || opc == OP_CLI) && !may_write(pe, vm, cpl, iopl);
    #1;
    check(gp_fault == exp_f, req, "gp_fault with retire", int'(gp_fault), int'(exp_f));
    if (exp_f)
      check(gp_err_code == 16'd0, "R10", "error code", int'(gp_err_code), 0);
    @(posedge clk); @(negedge clk);
    retire_vld = 1'b0; retire_opc = 8'h00;
    #1;
    check(gp_fault == 1'b0, "R10", "fault after retire", int'(gp_fault), 0);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    ext_irq_req = 1'b1; #1;
    check(iflag_o == 0, "R1", "flag after reset", int'(iflag_o), 0);
    check(ext_irq_take == 0, "R1", "take after reset", int'(ext_irq_take), 0);
    check(gp_fault == 0, "R1", "fault after reset", int'(gp_fault), 0);
    ext_irq_req = 1'b0;
  endtask

  task automatic t_real_mode();
    do_reset();
    do_retire(OP_STI, 1'b0, 1'b1, 3, 0, "R2");
    check(iflag_o == 1, "R2", "real mode set", int'(iflag_o), 1);
    do_retire(OP_CLI, 1'b0, 1'b0, 3, 0, "R5");
    check(iflag_o == 0, "R5", "real mode clear", int'(iflag_o), 0);
  endtask

  task automatic t_prot_mode();
    do_reset();
    do_retire(OP_STI, 1'b1, 1'b0, 3, 2, "R3");
    check(iflag_o == 0, "R3", "denied set keeps flag", int'(iflag_o), 0);
    do_retire(OP_STI, 1'b1, 1'b0, 2, 2, "R3");
    check(iflag_o == 1, "R3", "equal levels set", int'(iflag_o), 1);
    do_retire(OP_CLI, 1'b1, 1'b0, 0, 1, "R5");
    check(iflag_o == 0, "R5", "privileged clear", int'(iflag_o), 0);
  endtask

  task automatic t_v86_mode();
    do_reset();
    do_retire(OP_STI, 1'b1, 1'b1, 0, 2, "R4");
    check(iflag_o == 0, "R4", "v86 level 2 set denied", int'(iflag_o), 0);
    do_retire(OP_STI, 1'b1, 1'b1, 3, 3, "R4");
    check(iflag_o == 1, "R4", "v86 level 3 set", int'(iflag_o), 1);
    do_retire(OP_CLI, 1'b1, 1'b1, 0, 1, "R5");
    check(iflag_o == 1, "R5", "v86 denied clear keeps flag", int'(iflag_o), 1);
    do_retire(OP_CLI, 1'b1, 1'b0, 3, 1, "R5");
    check(iflag_o == 1, "R5", "prot denied clear keeps flag", int'(iflag_o), 1);
  endtask

  task automatic t_shadow();
    do_reset();
    ext_irq_req = 1'b1;
    do_retire(OP_STI, 1'b0, 1'b0, 0, 0, "R6");
    check(ext_irq_take == 0, "R6", "take during shadow", int'(ext_irq_take), 0);
    repeat (3) @(negedge clk);
    #1;
    check(ext_irq_take == 0, "R6", "shadow holds without retire", int'(ext_irq_take), 0);
    do_retire(OP_NOP, 1'b1, 1'b0, 3, 0, "R11");
    check(ext_irq_take == 1, "R6", "take after next retire", int'(ext_irq_take), 1);
    check(iflag_o == 1, "R11", "other opcode keeps flag", int'(iflag_o), 1);
    ext_irq_req = 1'b0; #1;
    check(ext_irq_take == 0, "R6", "take follows request", int'(ext_irq_take), 0);
  endtask

  task automatic t_set_then_clear();
    do_reset();
    ext_irq_req = 1'b1;
    do_retire(OP_STI, 1'b0, 1'b0, 0, 0, "R7");
    check(ext_irq_take == 0, "R7", "take after set", int'(ext_irq_take), 0);
    do_retire(OP_CLI, 1'b0, 1'b0, 0, 0, "R7");
    check(ext_irq_take == 0, "R7", "take after clear", int'(ext_irq_take), 0);
    check(iflag_o == 0, "R7", "flag after clear", int'(iflag_o), 0);
    ext_irq_req = 1'b0;
  endtask

  task automatic t_set_again();
    do_reset();
    ext_irq_req = 1'b1;
    do_retire(OP_STI, 1'b0, 1'b0, 0, 0, "R8");
    do_retire(OP_NOP, 1'b0, 1'b0, 0, 0, "R8");
    check(ext_irq_take == 1, "R8", "take open", int'(ext_irq_take), 1);
    do_retire(OP_STI, 1'b0, 1'b0, 0, 0, "R8");
    check(ext_irq_take == 1, "R8", "no gap after second set", int'(ext_irq_take), 1);
    ext_irq_req = 1'b0;
  endtask

  task automatic t_pass_through();
    do_reset();
    nmi_req = 1'b1; exc_req = 1'b1; #1;
    check(nmi_take == 1, "R9", "nmi with flag clear", int'(nmi_take), 1);
    check(exc_take == 1, "R9", "exception with flag clear", int'(exc_take), 1);
    do_retire(OP_STI, 1'b0, 1'b0, 0, 0, "R9");
    check(nmi_take == 1, "R9", "nmi during shadow", int'(nmi_take), 1);
    nmi_req = 1'b0; #1;
    check(nmi_take == 0, "R9", "nmi drop", int'(nmi_take), 0);
    check(exc_take == 1, "R9", "exception during shadow", int'(exc_take), 1);
    exc_req = 1'b0;
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    t_reset();
    t_real_mode();
    t_prot_mode();
    t_v86_mode();
    t_shadow();
    t_set_then_clear();
    t_set_again();
    t_pass_through();
    report();
  end

endmodule